// File: doc/BRIEF.md
# Shifter with carry and extend

This block is a registered 32-bit barrel shifter that performs logical left, logical right and arithmetic right shifts. Besides the shifted value it produces the carry bit and the extend bit a processor's condition code logic expects. It also produces the negative, zero and overflow flags.

Each cycle the block takes a data word, a shift count, a 2-bit shift kind and the previous carry flag. One clock later it presents the result and the flags on registered outputs. The carry rules differ for four ranges of count: zero, 1 to 31, exactly 32, and above 32. A count of zero keeps the old carry. Only the low six bits of the count are used. Operand selection and instruction decode belong to the surrounding datapath.

Top module: `shift_flag_unit`

## Requirements
- R1: Only the low 6 bits of `count_i` are used, so the effective shift amount is the count modulo 64. A count of 67 behaves exactly like a count of 3.
- R2: With an effective amount of zero, `result_o` equals the input value and `carry_o` equals `carry_i`, for every shift kind.
- R3: For amounts n from 1 to 31, the carry is the last bit shifted out. That is input bit 32-n for a left shift and input bit n-1 for either right shift.
- R4: A logical shift by exactly 32 gives a zero result. The carry is input bit 0 for a left shift and input bit 31 for a right shift.
- R5: A logical shift by 33 to 63 gives a zero result and a zero carry.
- R6: An arithmetic right shift by 32 or more fills the result with copies of input bit 31, and the carry equals input bit 31.
- R7: `extend_o` always equals `carry_o`.
- R8: `neg_o` is bit 31 of the result and `zero_o` is set exactly when the result is zero. `ovf_o` is always 0.
- R9: `kind_i` encodes 00 = logical left, 01 = logical right, 10 = arithmetic right. The code 11 passes the value through unchanged, with `carry_o` equal to `carry_i`.
- R10: Outputs are registered with one cycle of latency. A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| value_i | input | 32 | Data word to shift |
| count_i | input | 8 | Shift count; only the low 6 bits are used |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 pass |
| carry_i | input | 1 | Previous carry flag |
| result_o | output | 32 | Shifted result |
| carry_o | output | 1 | Carry flag |
| extend_o | output | 1 | Extend flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Overflow flag, always 0 |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that the relation between inputs in one cycle and outputs in the next holds from the first clock after reset is released. The inputs may take any value, including the reserved kind and counts whose upper bits are set. The bench drives all inputs on the falling edge, so they are stable at the rising edge. It holds reset for several cycles before the first operation and spreads its cases over every count range and every kind.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;
  typedef enum logic [1:0] {
    KIND_LSL  = 2'b00,
    KIND_LSR  = 2'b01,
    KIND_ASR  = 2'b10,
    KIND_PASS = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shift_rcore.sv
// Logarithmic right shifter on a word extended by one guard bit below the LSB.
// The guard bit ends up holding the last bit shifted out (the carry candidate).
module shift_rcore #(
  parameter int W    = 32,
  parameter int SH_W = 6
) (
  input  logic [W-1:0]    din,
  input  logic            fill,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout,
  output logic            last_out
);
  logic [W:0] stage [0:SH_W];

  assign stage[0] = {din, 1'b0};

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int S = 1 << i;
    if (S > W) begin : g_flush
      assign stage[i+1] = amt[i] ? {(W+1){fill}} : stage[i];
    end else begin : g_part
      assign stage[i+1] = amt[i] ? {{S{fill}}, stage[i][W:S]} : stage[i];
    end
  end

  assign dout     = stage[SH_W][W:1];
  assign last_out = stage[SH_W][0];
endmodule

// File: rtl/shift_nz_flags.sv
module shift_nz_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  output logic         neg,
  output logic         zero
);
  assign neg  = res[W-1];
  assign zero = ~|res;
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_flag_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     value_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       kind_i,
  input  logic             carry_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o,
  output logic             extend_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int SH_W = $clog2(W) + 1;

  shift_kind_e     kind;
  logic [SH_W-1:0] amt;
  logic [W-1:0]    rev_in, core_in, core_out, rev_out;
  logic            core_fill, core_last;
  logic [W-1:0]    res_d;
  logic            carry_d, neg_d, zero_d;

  assign kind = shift_kind_e'(kind_i);
  assign amt  = count_i[SH_W-1:0];

  // Left shifts reuse the right shifter on a bit-reversed word.
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev_in[g]  = value_i[W-1-g];
    assign rev_out[g] = core_out[W-1-g];
  end

  assign core_in   = (kind == KIND_LSL) ? rev_in : value_i;
  assign core_fill = (kind == KIND_ASR) & value_i[W-1];

  shift_rcore #(.W(W), .SH_W(SH_W)) u_core (
    .din      (core_in),
    .fill     (core_fill),
    .amt      (amt),
    .dout     (core_out),
    .last_out (core_last)
  );

  always_comb begin
    if (amt == '0 || kind == KIND_PASS) begin
      res_d   = value_i;
      carry_d = carry_i;
    end else if (kind == KIND_LSL) begin
      res_d   = rev_out;
      carry_d = core_last;
    end else begin
      res_d   = core_out;
      carry_d = core_last;
    end
  end

  shift_nz_flags #(.W(W)) u_flags (
    .res  (res_d),
    .neg  (neg_d),
    .zero (zero_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      extend_o <= 1'b0;
      neg_o    <= 1'b0;
      zero_o   <= 1'b0;
    end else begin
      result_o <= res_d;
      carry_o  <= carry_d;
      extend_o <= carry_d;
      neg_o    <= neg_d;
      zero_o   <= zero_d;
    end
  end

  assign ovf_o = 1'b0;

  AST_ZERO_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (count_i[SH_W-1:0] == '0) |=> (carry_o == $past(carry_i) && result_o == $past(value_i))); // R2
  AST_BIG_LOGICAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((kind_i == 2'b00 || kind_i == 2'b01) && count_i[SH_W-1:0] > W) |=> (result_o == '0 && !carry_o)); // R5
  AST_ARITH_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 2'b10 && count_i[SH_W-1:0] >= W) |=>
      (result_o == {W{$past(value_i[W-1])}} && carry_o == $past(value_i[W-1]))); // R6
  AST_EXTEND_MATCH: assert property (@(posedge clk) disable iff (rst)
    extend_o == carry_o); // R7
  AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(neg_o && zero_o)); // R8
  AST_PASS_KIND: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 2'b11) |=> (result_o == $past(value_i) && carry_o == $past(carry_i))); // R9
endmodule

// File: tb/tb_shift_flag_unit.sv
module tb_shift_flag_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] value_i = '0;
  logic [7:0]  count_i = '0;
  logic [1:0]  kind_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o, extend_o, neg_o, zero_o, ovf_o;
  int n_total = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  shift_flag_unit dut (
    .clk(clk), .rst(rst), .value_i(value_i), .count_i(count_i), .kind_i(kind_i),
    .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o), .extend_o(extend_o),
    .neg_o(neg_o), .zero_o(zero_o), .ovf_o(ovf_o)
  );

  // Packed expectation: {result, carry, extend, neg, zero, ovf}
  function automatic logic [36:0] model(logic [31:0] v, logic [7:0] cnt, logic [1:0] k, logic ci);
    int a;
    logic [31:0] r;
    logic c;
    a = cnt % 64;
    if (k == 2'b11 || a == 0) begin
      r = v; c = ci;
    end else if (k == 2'b00) begin
      if (a < 32)       begin r = v << a; c = v[32-a]; end
      else if (a == 32) begin r = '0;     c = v[0];    end
      else              begin r = '0;     c = 1'b0;    end
    end else if (k == 2'b01) begin
      if (a < 32)       begin r = v >> a; c = v[a-1];  end
      else if (a == 32) begin r = '0;     c = v[31];   end
      else              begin r = '0;     c = 1'b0;    end
    end else begin
      if (a < 32) begin r = 32'($signed(v) >>> a); c = v[a-1]; end
      else        begin r = {32{v[31]}};           c = v[31];  end
    end
    return {r, c, c, r[31], (r == 32'd0), 1'b0};
  endfunction

  task automatic check(string tag, logic [36:0] act, logic [36:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(string tag, logic [31:0] v, logic [7:0] cnt, logic [1:0] k, logic ci);
    @(negedge clk);
    value_i = v; count_i = cnt; kind_i = k; carry_i = ci;
    @(posedge clk);
    #2;
    check(tag, {result_o, carry_o, extend_o, neg_o, zero_o, ovf_o}, model(v, cnt, k, ci));
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R10 reset", {result_o, carry_o, extend_o, neg_o, zero_o, ovf_o}, 37'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_zero_count();
    run_case("R2 lsl zero c1", 32'hDEADBEEF, 8'd0, 2'b00, 1'b1);
    run_case("R2 asr zero c0", 32'h80000001, 8'd64, 2'b10, 1'b0);
    run_case("R2 lsr zero c1", 32'h00000000, 8'd128, 2'b01, 1'b1);
  endtask

  task automatic test_mid_counts();
    run_case("R3 lsl 1", 32'h80000000, 8'd1, 2'b00, 1'b0);
    run_case("R3 lsl 31", 32'h00000002, 8'd31, 2'b00, 1'b0);
    run_case("R3 lsr 1", 32'h00000001, 8'd1, 2'b01, 1'b0);
    run_case("R3 lsr 31", 32'hC0000000, 8'd31, 2'b01, 1'b0);
    run_case("R3 asr 4", 32'hF000000F, 8'd4, 2'b10, 1'b0);
    run_case("R3 asr 31 pos", 32'h40000000, 8'd31, 2'b10, 1'b1);
    for (int s = 1; s < 32; s += 5) begin
      run_case("R3 lsl sweep", 32'hA5C3_0F96, 8'(s), 2'b00, 1'b0);
      run_case("R3 lsr sweep", 32'hA5C3_0F96, 8'(s), 2'b01, 1'b1);
      run_case("R3 asr sweep", 32'hA5C3_0F96, 8'(s), 2'b10, 1'b0);
    end
  endtask

  task automatic test_exact32();
    run_case("R4 lsl 32 b0", 32'h00000001, 8'd32, 2'b00, 1'b0);
    run_case("R4 lsl 32 nb0", 32'hFFFFFFFE, 8'd32, 2'b00, 1'b1);
    run_case("R4 lsr 32 b31", 32'h80000000, 8'd32, 2'b01, 1'b0);
    run_case("R4 lsr 32 nb31", 32'h7FFFFFFF, 8'd32, 2'b01, 1'b1);
  endtask

  task automatic test_over32();
    run_case("R5 lsl 33", 32'hFFFFFFFF, 8'd33, 2'b00, 1'b1);
    run_case("R5 lsr 63", 32'hFFFFFFFF, 8'd63, 2'b01, 1'b1);
    run_case("R6 asr 32 neg", 32'h80000000, 8'd32, 2'b10, 1'b0);
    run_case("R6 asr 63 pos", 32'h7FFFFFFF, 8'd63, 2'b10, 1'b1);
    run_case("R6 asr 40 neg", 32'hFFFF0000, 8'd40, 2'b10, 1'b0);
  endtask

  task automatic test_modulo();
    run_case("R1 count 67 lsl", 32'h12345678, 8'd67, 2'b00, 1'b0);
    run_case("R1 count 255 lsr", 32'hFFFFFFFF, 8'd255, 2'b01, 1'b0);
    run_case("R1 count 160 asr", 32'h80000000, 8'd160, 2'b10, 1'b0);
  endtask

  task automatic test_pass_and_flags();
    run_case("R9 pass c1", 32'h0F0F0F0F, 8'd5, 2'b11, 1'b1);
    run_case("R9 pass c0", 32'h80000000, 8'd32, 2'b11, 1'b0);
    run_case("R8 zero flag", 32'h00000001, 8'd1, 2'b01, 1'b0);
    run_case("R8 neg flag", 32'h40000000, 8'd1, 2'b00, 1'b0);
    run_case("R7 extend follows carry", 32'h00000004, 8'd3, 2'b01, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    n_total++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    test_reset();
    test_zero_count();
    test_mid_counts();
    test_exact32();
    test_over32();
    test_modulo();
    test_pass_and_flags();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule